// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point words and returns a packed 32-bit result one clock after the operands are offered. Each word holds a sign in bit 31, an exponent biased by 127 in bits 30..23 and a 23-bit fraction in bits 22..0. A normal value carries an implicit leading 1 ahead of its fraction. Operands with a stored exponent of 0 are treated as zero. Results too small for a normal value are returned as +0. Rounding is always to nearest, with ties going to even.

The datapath runs in a fixed order. It unpacks both words and orders the two finite operands by magnitude. It right-shifts the smaller significand by the exponent difference, keeping guard, round and sticky bits. It then adds or subtracts the significands according to the effective signs. The sum is normalized: one place right on a carry-out, or several places left after cancellation. It is rounded, renormalized if rounding carries out, checked for exponent overflow and packed. Infinities and NaNs bypass this path and raise a separate flag.

A caller presents `a_i`, `b_i` and `sub_i` with `valid_i` high for one cycle. It reads `result_o`, `ovf_o` and `special_o` when `valid_o` rises on the next cycle. The outputs keep their last values while no new operation arrives.

Top module: `fpadd_unit`

## Requirements
- R1: `valid_o` is high exactly one cycle after `valid_i` was high and low otherwise; `result_o`, `ovf_o` and `special_o` change only one cycle after a cycle with `valid_i` high and otherwise hold, whatever `a_i`, `b_i` and `sub_i` carry.
- R2: For two finite normal operands (exponent field 1..254), `result_o` equals their exact sum rounded to a 24-bit significand, packed as sign bit 31, exponent biased by 127 in bits 30..23 and fraction in bits 22..0.
- R3: When the rounded result exponent reaches 255 or more, `result_o` is the infinity of the result's sign (exponent 255, fraction 0), `ovf_o` is 1 and `special_o` is 0.
- R4: If either operand is a NaN (exponent 255, nonzero fraction), or the two operands are infinities of opposite effective sign, `result_o` is 0x7FC00000, `special_o` is 1 and `ovf_o` is 0.
- R5: If exactly one operand, or both with equal effective sign, is an infinity (exponent 255, fraction 0) and neither is a NaN, `result_o` is that infinity with its effective sign, `special_o` is 1 and `ovf_o` is 0.
- R6: `sub_i` = 1 inverts the sign of `b_i` before the operation; `sub_i` = 0 adds.
- R7: A sum whose leading 1 falls several places below the larger operand's is renormalized by a left shift; 0x3F000000 plus 0xBEE00000 gives 0x3D800000.
- R8: An operand with exponent field 0 counts as zero whatever its fraction; a result whose final biased exponent is 0 or less is returned as 0x00000000.
- R9: An exactly zero result is returned as 0x00000000 (+0) for every sign combination, including -0 plus -0.
- R10: A result exactly halfway between two neighbours rounds to the one with an even last fraction bit: 0x3F800000 + 0x33800000 gives 0x3F800000, and 0x3F800001 + 0x33800000 gives 0x3F800002.
- R11: While `rst_ni` is low and until the first accepted operation, `valid_o`, `result_o`, `ovf_o` and `special_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and operation present this cycle |
| sub_i | input | 1 | 1 = a minus b, 0 = a plus b |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| valid_o | output | 1 | Result registered from the previous cycle's operation |
| result_o | output | 32 | Packed rounded result |
| ovf_o | output | 1 | Result exponent overflowed, result is signed infinity |
| special_o | output | 1 | An operand was infinity or NaN |

## Verification
On every cycle the assertions check the one-cycle valid timing and the holding of idle outputs. They also check that an overflow always packs a clean infinity with the special flag low, that any NaN or non-overflow infinity at the output comes with the special flag, and that a zero result never carries a negative sign. The values themselves can only be shown by the bench's scenarios: correct rounding, including ties to even, left renormalization after cancellation, flushing of small operands and results, and sign handling under subtraction. The bench compares them against an exact-integer model of the sum on every clock.

// File: rtl/fpadd_pkg.sv
`timescale 1ns/1ps
package fpadd_pkg;
  localparam int unsigned FPA_EXP_W  = 8;
  localparam int unsigned FPA_FRAC_W = 23;
  // guard, round, sticky
  localparam int unsigned FPA_GRS_W  = 3;
endpackage

// File: rtl/fpadd_unpack.sv
`timescale 1ns/1ps
module fpadd_unpack #(
  parameter int unsigned EXP_W  = fpadd_pkg::FPA_EXP_W,
  parameter int unsigned FRAC_W = fpadd_pkg::FPA_FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0]       word_i,
  input  logic                    flip_i,
  output logic                    sign_o,
  output logic [EXP_W-1:0]        exp_o,
  output logic [FRAC_W:0]         sig_o,
  output logic [EXP_W+FRAC_W-1:0] mag_o,
  output logic                    inf_o,
  output logic                    nan_o
);
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic              e_zero, e_top;

  assign e      = word_i[WORD_W-2 -: EXP_W];
  assign f      = word_i[FRAC_W-1:0];
  assign e_zero = (e == '0);
  assign e_top  = (e == '1);

  assign sign_o = word_i[WORD_W-1] ^ flip_i;
  assign exp_o  = e;
  // exponent 0: flushed to zero, fraction ignored
  assign sig_o  = e_zero ? '0 : {1'b1, f};
  assign mag_o  = e_zero ? '0 : {e, f};
  assign inf_o  = e_top & (f == '0);
  assign nan_o  = e_top & (f != '0);
endmodule

// File: rtl/fpadd_align.sv
`timescale 1ns/1ps
module fpadd_align #(
  parameter int unsigned EXP_W  = fpadd_pkg::FPA_EXP_W,
  parameter int unsigned FRAC_W = fpadd_pkg::FPA_FRAC_W,
  parameter int unsigned GRS_W  = fpadd_pkg::FPA_GRS_W,
  localparam int unsigned EXT_W = FRAC_W + 1 + GRS_W
) (
  input  logic [EXP_W-1:0] exp_big_i,
  input  logic [EXP_W-1:0] exp_small_i,
  input  logic [FRAC_W:0]  sig_small_i,
  output logic [EXT_W-1:0] sig_aligned_o
);
  localparam int unsigned SH_W   = $clog2(EXT_W + 1);
  localparam int unsigned MAX_SH = (1 << SH_W) - 1;

  logic [EXP_W-1:0] diff;
  logic [SH_W-1:0]  sh;
  logic [EXT_W-1:0] stg [SH_W+1];

  assign diff   = exp_big_i - exp_small_i;
  // any distance past the word width shifts everything into sticky
  assign sh     = (diff > EXP_W'(MAX_SH)) ? SH_W'(MAX_SH) : diff[SH_W-1:0];
  assign stg[0] = {sig_small_i, {GRS_W{1'b0}}};

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned DIST = 1 << k;
    logic lost;
    if (DIST < EXT_W) begin : g_part
      assign lost = |stg[k][DIST-1:0];
    end else begin : g_all
      assign lost = |stg[k];
    end
    assign stg[k+1] = sh[k] ? ((stg[k] >> DIST) | EXT_W'(lost)) : stg[k];
  end

  assign sig_aligned_o = stg[SH_W];
endmodule

// File: rtl/fpadd_norm.sv
`timescale 1ns/1ps
module fpadd_norm #(
  parameter int unsigned EXP_W  = fpadd_pkg::FPA_EXP_W,
  parameter int unsigned FRAC_W = fpadd_pkg::FPA_FRAC_W,
  parameter int unsigned GRS_W  = fpadd_pkg::FPA_GRS_W,
  localparam int unsigned EXT_W = FRAC_W + 1 + GRS_W,
  localparam int unsigned ES_W  = EXP_W + 2
) (
  input  logic [EXT_W:0]          sum_i,
  input  logic [EXP_W-1:0]        exp_i,
  output logic [EXT_W-1:0]        mant_o,
  output logic signed [ES_W-1:0]  exp_o,
  output logic                    zero_o
);
  localparam int unsigned LZ_W = $clog2(EXT_W + 1);

  logic [LZ_W-1:0]        lz;
  logic signed [ES_W-1:0] e_base;

  always_comb begin
    lz = LZ_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++) begin
      if (sum_i[i]) lz = LZ_W'(EXT_W - 1 - i);
    end
  end

  assign e_base = $signed({2'b00, exp_i});
  assign zero_o = (sum_i == '0);

  always_comb begin
    if (sum_i[EXT_W]) begin
      mant_o = sum_i[EXT_W:1] | EXT_W'(sum_i[0]);
      exp_o  = e_base + $signed(ES_W'(1));
    end else begin
      mant_o = sum_i[EXT_W-1:0] << lz;
      exp_o  = e_base - $signed(ES_W'(lz));
    end
  end
endmodule

// File: rtl/fpadd_round.sv
`timescale 1ns/1ps
module fpadd_round #(
  parameter int unsigned EXP_W  = fpadd_pkg::FPA_EXP_W,
  parameter int unsigned FRAC_W = fpadd_pkg::FPA_FRAC_W,
  parameter int unsigned GRS_W  = fpadd_pkg::FPA_GRS_W,
  localparam int unsigned EXT_W  = FRAC_W + 1 + GRS_W,
  localparam int unsigned ES_W   = EXP_W + 2,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic                   sign_i,
  input  logic [EXT_W-1:0]       mant_i,
  input  logic signed [ES_W-1:0] exp_i,
  input  logic                   zero_i,
  output logic [WORD_W-1:0]      res_o,
  output logic                   ovf_o
);
  localparam int unsigned MW      = FRAC_W + 1;
  localparam int unsigned EXP_TOP = (1 << EXP_W) - 1;

  logic                   lsb_b, guard_b, round_b, sticky_b, up;
  logic [MW:0]            rnd;
  logic [FRAC_W-1:0]      frac;
  logic signed [ES_W-1:0] e_fin;
  logic                   e_pos;

  assign lsb_b    = mant_i[GRS_W];
  assign guard_b  = mant_i[GRS_W-1];
  assign round_b  = mant_i[GRS_W-2];
  assign sticky_b = |mant_i[GRS_W-3:0];
  // nearest, ties to even
  assign up       = guard_b & (round_b | sticky_b | lsb_b);
  assign rnd      = {1'b0, mant_i[EXT_W-1:GRS_W]} + (MW+1)'(up);
  assign frac     = rnd[MW] ? rnd[MW-1:1] : rnd[FRAC_W-1:0];
  assign e_fin    = exp_i + $signed(ES_W'(rnd[MW]));
  assign e_pos    = !e_fin[ES_W-1] && (e_fin != '0);

  always_comb begin
    res_o = '0;
    ovf_o = 1'b0;
    if (!zero_i && e_pos) begin
      if (e_fin >= $signed(ES_W'(EXP_TOP))) begin
        res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        ovf_o = 1'b1;
      end else begin
        res_o = {sign_i, e_fin[EXP_W-1:0], frac};
      end
    end
  end
endmodule

// File: rtl/fpadd_unit.sv
`timescale 1ns/1ps
module fpadd_unit #(
  parameter int unsigned EXP_W  = fpadd_pkg::FPA_EXP_W,
  parameter int unsigned FRAC_W = fpadd_pkg::FPA_FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sub_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o,
  output logic              ovf_o,
  output logic              special_o
);
  localparam int unsigned GRS_W = fpadd_pkg::FPA_GRS_W;
  localparam int unsigned MW    = FRAC_W + 1;
  localparam int unsigned EXT_W = MW + GRS_W;
  localparam int unsigned ES_W  = EXP_W + 2;
  localparam int unsigned MAG_W = EXP_W + FRAC_W;
  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [WORD_W-1:0] op_word [2];
  logic              op_flip [2];
  logic              op_sign [2];
  logic              op_inf  [2];
  logic              op_nan  [2];
  logic [EXP_W-1:0]  op_exp  [2];
  logic [MW-1:0]     op_sig  [2];
  logic [MAG_W-1:0]  op_mag  [2];

  assign op_word[0] = a_i;
  assign op_word[1] = b_i;
  assign op_flip[0] = 1'b0;
  assign op_flip[1] = sub_i;

  for (genvar i = 0; i < 2; i++) begin : g_unpack
    fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .word_i (op_word[i]),
      .flip_i (op_flip[i]),
      .sign_o (op_sign[i]),
      .exp_o  (op_exp[i]),
      .sig_o  (op_sig[i]),
      .mag_o  (op_mag[i]),
      .inf_o  (op_inf[i]),
      .nan_o  (op_nan[i])
    );
  end

  // order by magnitude so the significand difference is never negative
  logic             a_big;
  logic             sign_big, sign_small;
  logic [EXP_W-1:0] exp_big, exp_small;
  logic [MW-1:0]    sig_big, sig_small;

  assign a_big      = op_mag[0] >= op_mag[1];
  assign sign_big   = a_big ? op_sign[0] : op_sign[1];
  assign sign_small = a_big ? op_sign[1] : op_sign[0];
  assign exp_big    = a_big ? op_exp[0]  : op_exp[1];
  assign exp_small  = a_big ? op_exp[1]  : op_exp[0];
  assign sig_big    = a_big ? op_sig[0]  : op_sig[1];
  assign sig_small  = a_big ? op_sig[1]  : op_sig[0];

  logic [EXT_W-1:0] small_al, big_ext;

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRS_W(GRS_W)) u_align (
    .exp_big_i     (exp_big),
    .exp_small_i   (exp_small),
    .sig_small_i   (sig_small),
    .sig_aligned_o (small_al)
  );

  logic             eff_sub;
  logic [EXT_W:0]   sum;

  assign big_ext = {sig_big, {GRS_W{1'b0}}};
  assign eff_sub = sign_big ^ sign_small;
  assign sum     = eff_sub ? ({1'b0, big_ext} - {1'b0, small_al})
                           : ({1'b0, big_ext} + {1'b0, small_al});

  logic [EXT_W-1:0]       norm_mant;
  logic signed [ES_W-1:0] norm_exp;
  logic                   norm_zero;

  fpadd_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRS_W(GRS_W)) u_norm (
    .sum_i  (sum),
    .exp_i  (exp_big),
    .mant_o (norm_mant),
    .exp_o  (norm_exp),
    .zero_o (norm_zero)
  );

  logic [WORD_W-1:0] fin_res;
  logic              fin_ovf;

  fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRS_W(GRS_W)) u_round (
    .sign_i (sign_big),
    .mant_i (norm_mant),
    .exp_i  (norm_exp),
    .zero_i (norm_zero),
    .res_o  (fin_res),
    .ovf_o  (fin_ovf)
  );

  logic              is_special, is_nan_out;
  logic [WORD_W-1:0] spec_res, nxt_res;

  assign is_special = op_inf[0] | op_inf[1] | op_nan[0] | op_nan[1];
  assign is_nan_out = op_nan[0] | op_nan[1] |
                      (op_inf[0] & op_inf[1] & (op_sign[0] != op_sign[1]));
  assign spec_res   = is_nan_out ? QNAN
                    : {(op_inf[0] ? op_sign[0] : op_sign[1]), {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  assign nxt_res    = is_special ? spec_res : fin_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      ovf_o     <= 1'b0;
      special_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= nxt_res;
        ovf_o     <= fin_ovf & ~is_special;
        special_o <= is_special;
      end
    end
  end

  // R1
  p_valid_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(ovf_o) && $stable(special_o)));
  // R3
  p_ovf_inf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (result_o[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}) && !special_o);
  // R4
  p_nan_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((result_o[WORD_W-2 -: EXP_W] == '1) && (result_o[FRAC_W-1:0] != '0))
      |-> (special_o && !ovf_o));
  // R5
  p_inf_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}) |-> (ovf_o ^ special_o));
  // R9
  p_pos_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o[WORD_W-2:0] == '0) |-> !result_o[WORD_W-1]);
endmodule

// File: tb/sim_fpadd_unit.sv
`timescale 1ns/1ps
module sim_fpadd_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        sub_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        ovf_o;
  logic        special_o;

  always #4 clk_i = ~clk_i;

  fpadd_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sub_i(sub_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o),
    .ovf_o(ovf_o), .special_o(special_o)
  );

  int n_run = 0;
  int n_fail = 0;

  logic        exp_valid = 1'b0;
  logic [31:0] exp_res = '0;
  logic        exp_ovf = 1'b0;
  logic        exp_spec = 1'b0;
  string       exp_tag = "R11";

  function automatic void ref_add(input logic [31:0] a, input logic [31:0] b, input logic sub,
                                  output logic [31:0] r, output logic ov, output logic sp);
    logic        sa, sb, sl, ss;
    int          ea, eb, el, es, d, msb, e, sh;
    logic [63:0] ml, ms, x, kept, rem, half;
    logic [31:0] wl;
    sa = a[31]; sb = b[31] ^ sub;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    r = '0; ov = 1'b0; sp = 1'b0;
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) begin
      r = 32'h7FC0_0000; sp = 1'b1; return;
    end
    if (ea == 255 && eb == 255) begin
      sp = 1'b1;
      r = (sa != sb) ? 32'h7FC0_0000 : {sa, 8'hFF, 23'h0};
      return;
    end
    if (ea == 255) begin sp = 1'b1; r = {sa, 8'hFF, 23'h0}; return; end
    if (eb == 255) begin sp = 1'b1; r = {sb, 8'hFF, 23'h0}; return; end
    if (ea == 0 && eb == 0) return;
    if (ea == 0) begin r = {sb, b[30:0]}; return; end
    if (eb == 0) begin r = {sa, a[30:0]}; return; end
    if (a[30:0] >= b[30:0]) begin
      sl = sa; ss = sb; el = ea; es = eb; wl = a;
      ml = {40'd0, 1'b1, a[22:0]}; ms = {40'd0, 1'b1, b[22:0]};
    end else begin
      sl = sb; ss = sa; el = eb; es = ea; wl = b;
      ml = {40'd0, 1'b1, b[22:0]}; ms = {40'd0, 1'b1, a[22:0]};
    end
    d = el - es;
    if (d >= 26) begin r = {sl, wl[30:0]}; return; end
    x = (sl == ss) ? ((ml << d) + ms) : ((ml << d) - ms);
    if (x == 0) return;
    msb = 0;
    for (int i = 0; i < 64; i++) if (x[i]) msb = i;
    e = es + msb - 23;
    if (msb > 23) begin
      sh = msb - 23;
      kept = x >> sh;
      rem = x & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && kept[0])) kept = kept + 64'd1;
      if (kept == (64'd1 << 24)) begin kept = kept >> 1; e = e + 1; end
    end else begin
      kept = x << (23 - msb);
    end
    if (e >= 255) begin r = {sl, 8'hFF, 23'h0}; ov = 1'b1; end
    else if (e <= 0) r = '0;
    else r = {sl, 8'(e), kept[22:0]};
  endfunction

  task automatic check_out();
    n_run++;
    if (valid_o !== exp_valid || result_o !== exp_res || ovf_o !== exp_ovf || special_o !== exp_spec) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b res=%h ovf=%0b spec=%0b, expected valid=%0b res=%h ovf=%0b spec=%0b",
               exp_tag, valid_o, result_o, ovf_o, special_o, exp_valid, exp_res, exp_ovf, exp_spec);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [31:0] a, input logic [31:0] b,
                      input string tag);
    @(negedge clk_i);
    check_out();
    valid_i = v; sub_i = s; a_i = a; b_i = b;
    exp_valid = v;
    if (v) begin
      ref_add(a, b, s, exp_res, exp_ovf, exp_spec);
      exp_tag = tag;
    end else begin
      exp_tag = "R1 hold";
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] mk(input logic s, input int e, input logic [22:0] f);
    int ec;
    ec = (e < 1) ? 1 : ((e > 254) ? 254 : e);
    return {s, 8'(ec), f};
  endfunction

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got no finish, expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R11: reset values checked by the first steps
    step(1'b0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, "R11");
    step(1'b1, 1'b0, 32'h3F80_0000, 32'h3F80_0000, "R2 1+1");
    step(1'b1, 1'b0, 32'h3FC0_0000, 32'h4010_0000, "R2 1.5+2.25");
    step(1'b1, 1'b1, 32'h4040_0000, 32'h3F80_0000, "R6 3-1");
    step(1'b1, 1'b1, 32'h3F80_0000, 32'hC000_0000, "R6 1-(-2)");
    step(1'b1, 1'b0, 32'h3F00_0000, 32'hBEE0_0000, "R7 cancel");
    step(1'b1, 1'b1, 32'h3F80_0001, 32'h3F80_0000, "R7 deep cancel");
    step(1'b1, 1'b0, 32'h7F7F_FFFF, 32'h7F7F_FFFF, "R3 pos ovf");
    step(1'b1, 1'b1, 32'hFF7F_FFFF, 32'h7F7F_FFFF, "R3 neg ovf");
    step(1'b1, 1'b0, 32'h7FC0_0001, 32'h3F80_0000, "R4 nan in");
    step(1'b1, 1'b1, 32'h7F80_0000, 32'h7F80_0000, "R4 inf-inf");
    step(1'b1, 1'b0, 32'h7F80_0000, 32'h3F80_0000, "R5 inf+1");
    step(1'b1, 1'b1, 32'h3F80_0000, 32'h7F80_0000, "R5 1-inf");
    step(1'b1, 1'b0, 32'hFF80_0000, 32'hFF80_0000, "R5 -inf+-inf");
    step(1'b1, 1'b0, 32'h0000_0001, 32'h3F80_0000, "R8 denorm in");
    step(1'b1, 1'b1, 32'h0080_0001, 32'h0080_0000, "R8 underflow");
    step(1'b1, 1'b1, 32'h4120_0000, 32'h4120_0000, "R9 x-x");
    step(1'b1, 1'b0, 32'hC120_0000, 32'h4120_0000, "R9 -x+x");
    step(1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000, "R9 -0+-0");
    step(1'b1, 1'b0, 32'h3F80_0000, 32'h3380_0000, "R10 tie even");
    step(1'b1, 1'b0, 32'h3F80_0001, 32'h3380_0000, "R10 tie odd");
    step(1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, "R1");
    step(1'b0, 1'b0, 32'h7FC0_0000, 32'h7F80_0000, "R1");
    for (int i = 0; i < 1200; i++) begin
      logic [31:0] ra, rb;
      int ea, md;
      md = i % 4;
      ea = 1 + int'($urandom % 254);
      case (md)
        0: begin ra = $urandom; rb = $urandom; end
        1: begin
          ra = mk($urandom % 2 == 1, ea, 23'($urandom));
          rb = mk($urandom % 2 == 1, ea - int'($urandom % 3), 23'($urandom));
        end
        2: begin
          ra = mk($urandom % 2 == 1, ea, 23'($urandom));
          rb = mk($urandom % 2 == 1, ea - int'($urandom % 30), 23'($urandom));
        end
        default: begin
          ra = mk($urandom % 2 == 1, 252 + int'($urandom % 3), 23'($urandom));
          rb = mk($urandom % 2 == 1, 250 + int'($urandom % 5), 23'($urandom));
        end
      endcase
      step(1'b1, 1'($urandom % 2), ra, rb, "R2 random");
      if (i % 7 == 0) step(1'b0, 1'($urandom % 2), $urandom, $urandom, "R1");
    end
    step(1'b0, 1'b0, '0, '0, "R1");
    step(1'b0, 1'b0, '0, '0, "R1");
    finish_run();
  end
endmodule